// File: doc/BRIEF.md
# ADC Trigger Scheduler with Postscaler and Event Offset

This block turns the compare-event pulses of a PWM time base into two ADC start-of-conversion pulses. Each of the three compare pulses (A, B, C) can be routed to either trigger channel through its own enable bit, and each channel sees a single candidate event: the OR of its enabled sources. Several sources pulsing in the same cycle count as one candidate.

Channel 1 thins its candidates with a postscaler. A 5-bit ratio field N passes one of every N+1 candidates. A 5-bit offset field M selects which candidate within each window of N+1 fires. An event counter holds the position in the window. It is cleared by reset and while the generator-off input is high. Channel 2 passes every enabled candidate. Both outputs are registered single-cycle pulses.

Top module: `adc_trig_sched`

## Requirements
- R1: Channel 1's candidate is the OR of compare events A (bit 0 of `evt` and `t1_src_en`), B (bit 1) and C (bit 2), each gated by its own enable bit.
- R2: Channel 2's candidate is the same OR gated by `t2_src_en`. Bit positions match those of R1. The `t2_src_en` bits act independently of `t1_src_en`, and channel 2 has no postscaler.
- R3: With ratio field N, `adc_trig1` fires for exactly one of every N+1 channel-1 candidates.
- R4: With N = 0 and offset 0, every channel-1 candidate produces an `adc_trig1` pulse.
- R5: Counting channel-1 candidates from 0 after the last clear, candidate k fires when k mod (N+1) equals M mod (N+1).
- R6: An offset M larger than N wraps modulo N+1. For example, N = 4 with M = 9 fires on candidate 4 of each window.
- R7: While `gen_off` is high, the event counter clears to zero and neither output pulses in the following cycle.
- R8: Each output is a registered single-cycle pulse. It is high in the clock cycle after the edge that sampled its qualifying event. Both outputs are 0 after reset.
- R9: Several enabled sources pulsing in the same cycle form one candidate and advance the counter by one.
- R10: A pulse on a source whose enable bit is 0 causes no output pulse and does not advance the channel-1 counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_off | input | 1 | Generator off; clears the counter and suppresses both triggers |
| evt | input | 3 | Compare-event pulses: bit 0 = A, bit 1 = B, bit 2 = C |
| t1_src_en | input | 3 | Channel 1 source enables |
| t2_src_en | input | 3 | Channel 2 source enables |
| t1_ratio | input | 5 | Postscale field N; passes 1 of N+1 candidates |
| t1_offset | input | 5 | Offset field M; selects the firing candidate in each window |
| adc_trig1 | output | 1 | Channel 1 ADC trigger pulse |
| adc_trig2 | output | 1 | Channel 2 ADC trigger pulse |

## Verification
The hardest situations to reach from the ports depend on the counter's hidden phase: a wrapped offset, a full 32-event window, and a clear in the middle of a window. The bench walks a table of configurations. Before each row it pulses `gen_off` so that the counter starts from a known zero. It then sends enough back-to-back candidates to cover one or more full windows. A reference index kept in the bench predicts every firing position. Directed cases then reveal the counter position after disabled-source pulses and after a mid-window clear, by checking at which later candidate `adc_trig1` fires.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int DEF_SRC_N = 3;
  localparam int DEF_CNT_W = 5;
  localparam int NUM_CH    = 2;
endpackage

// File: rtl/trig_src_merge.sv
module trig_src_merge #(
  parameter int SRC_N = 3
) (
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] en,
  output logic             cand
);
  // Sources that fire together collapse into one candidate
  always_comb cand = |(evt & en);
endmodule

// File: rtl/trig_postscale.sv
module trig_postscale #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off,
  input  logic             cand,
  input  logic [CNT_W-1:0] ratio,
  input  logic [CNT_W-1:0] offset,
  output logic             hit
);
  localparam int DIV_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] tgt_wide;
  logic [CNT_W-1:0] target;

  always_comb begin
    divisor  = {1'b0, ratio} + DIV_W'(1);
    tgt_wide = {1'b0, offset} % divisor;
    target   = tgt_wide[CNT_W-1:0];
    hit      = cand && !off && (cnt == target);
  end

  always_ff @(posedge clk) begin
    if (rst || off) begin
      cnt <= '0;
    end else if (cand) begin
      if (cnt >= ratio) cnt <= '0;
      else              cnt <= cnt + CNT_W'(1);
    end
  end

  // Counter advances by one per candidate inside the window
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!off && cand && cnt < ratio) |=> cnt == $past(cnt) + CNT_W'(1));

  // Idle cycles leave the phase untouched (R10)
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!off && !cand) |=> $stable(cnt));

  // Generator off clears the position
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (rst)
    off |=> cnt == '0);
endmodule

// File: rtl/trig_out_reg.sv
module trig_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched #(
  parameter int SRC_N = adc_trig_pkg::DEF_SRC_N,
  parameter int CNT_W = adc_trig_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_off,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] t1_src_en,
  input  logic [SRC_N-1:0] t2_src_en,
  input  logic [CNT_W-1:0] t1_ratio,
  input  logic [CNT_W-1:0] t1_offset,
  output logic             adc_trig1,
  output logic             adc_trig2
);
  localparam int NCH = adc_trig_pkg::NUM_CH;

  logic [SRC_N-1:0] ch_en [NCH];
  logic [NCH-1:0]   cand;
  logic [NCH-1:0]   fire;
  logic [NCH-1:0]   trig_q;

  assign ch_en[0] = t1_src_en;
  assign ch_en[1] = t2_src_en;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    trig_src_merge #(.SRC_N(SRC_N)) u_merge (
      .evt  (evt),
      .en   (ch_en[ch]),
      .cand (cand[ch])
    );
    if (ch == 0) begin : g_scaled
      trig_postscale #(.CNT_W(CNT_W)) u_ps (
        .clk    (clk),
        .rst    (rst),
        .off    (gen_off),
        .cand   (cand[ch]),
        .ratio  (t1_ratio),
        .offset (t1_offset),
        .hit    (fire[ch])
      );
    end else begin : g_direct
      assign fire[ch] = cand[ch] && !gen_off;
    end
    trig_out_reg u_out (
      .clk (clk),
      .rst (rst),
      .d   (fire[ch]),
      .q   (trig_q[ch])
    );
  end

  assign adc_trig1 = trig_q[0];
  assign adc_trig2 = trig_q[1];

  assert_trig1_cause_R1: assert property (@(posedge clk) disable iff (rst)
    adc_trig1 |-> $past(|(evt & t1_src_en)));

  assert_trig2_cause_R2: assert property (@(posedge clk) disable iff (rst)
    adc_trig2 |-> $past(|(evt & t2_src_en)));

  assert_ratio0_all_R4: assert property (@(posedge clk) disable iff (rst)
    (|(evt & t1_src_en) && t1_ratio == '0 && t1_offset == '0 && !gen_off) |=> adc_trig1);

  assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
    gen_off |=> (!adc_trig1 && !adc_trig2));

  assert_trig2_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(evt & t2_src_en) && !gen_off) |=> adc_trig2);
endmodule

// File: tb/sim_adc_trig_sched.sv
module sim_adc_trig_sched;
  logic       clk = 1'b0;
  logic       rst;
  logic       gen_off;
  logic [2:0] evt;
  logic [2:0] t1_src_en;
  logic [2:0] t2_src_en;
  logic [4:0] t1_ratio;
  logic [4:0] t1_offset;
  logic       adc_trig1;
  logic       adc_trig2;

  int errors = 0;
  int checks = 0;
  int k = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_trig_sched u0 (
    .clk(clk), .rst(rst), .gen_off(gen_off), .evt(evt),
    .t1_src_en(t1_src_en), .t2_src_en(t2_src_en),
    .t1_ratio(t1_ratio), .t1_offset(t1_offset),
    .adc_trig1(adc_trig1), .adc_trig2(adc_trig2)
  );

  // {ratio, offset, t1_en, t2_en, pattern, count}
  localparam logic [26:0] VEC [8] = '{
    {5'd0,  5'd0,  3'b001, 3'b000, 3'b001, 8'd4},
    {5'd3,  5'd0,  3'b001, 3'b010, 3'b011, 8'd9},
    {5'd3,  5'd2,  3'b111, 3'b100, 3'b100, 8'd9},
    {5'd4,  5'd9,  3'b010, 3'b001, 3'b011, 8'd11},
    {5'd31, 5'd31, 3'b100, 3'b111, 3'b100, 8'd40},
    {5'd1,  5'd0,  3'b011, 3'b000, 3'b011, 8'd5},
    {5'd5,  5'd5,  3'b110, 3'b011, 3'b101, 8'd13},
    {5'd2,  5'd1,  3'b000, 3'b111, 3'b111, 8'd4}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (k=%0d)", req, got, exp, k);
    end
  endtask

  // Drive one cycle, predict both outputs, sample one clock later
  task automatic step(input logic [2:0] e, input logic off, input string req);
    logic c1, e1, e2;
    @(negedge clk);
    evt = e;
    gen_off = off;
    c1 = |(e & t1_src_en);
    e2 = (|(e & t2_src_en)) && !off;
    e1 = c1 && !off &&
         ((k % (int'(t1_ratio) + 1)) == (int'(t1_offset) % (int'(t1_ratio) + 1)));
    if (off) k = 0;
    else if (c1) k++;
    @(posedge clk);
    #1;
    chk(adc_trig1, e1, {req, " trig1"});
    chk(adc_trig2, e2, {req, " trig2"});
  endtask

  task automatic cfg(input logic [4:0] r, input logic [4:0] o,
                     input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    t1_ratio = r; t1_offset = o; t1_src_en = a; t2_src_en = b;
    evt = '0; gen_off = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; gen_off = 1'b0; evt = '0;
    t1_src_en = '0; t2_src_en = '0; t1_ratio = '0; t1_offset = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(adc_trig1, 1'b0, "R8 reset");
    chk(adc_trig2, 1'b0, "R8 reset");
    @(negedge clk);
    rst = 1'b0;
    // Reset-default enables: nothing passes
    step(3'b111, 1'b0, "R10 defaults");

    // Table walk: R3 R4 R5 R6 R1 R2 R9
    for (int i = 0; i < 8; i++) begin
      cfg(VEC[i][26:22], VEC[i][21:17], VEC[i][16:14], VEC[i][13:11]);
      step(3'b000, 1'b1, "R7 clear");
      for (int j = 0; j < int'(VEC[i][7:0]); j++)
        step(VEC[i][10:8], 1'b0, $sformatf("R5 row%0d", i));
    end

    // R9: all three sources together count once
    cfg(5'd2, 5'd1, 3'b111, 3'b000);
    step(3'b000, 1'b1, "R7 clear");
    step(3'b111, 1'b0, "R9 k0");
    step(3'b111, 1'b0, "R9 k1 fires");
    step(3'b111, 1'b0, "R9 k2");
    step(3'b001, 1'b0, "R9 k3");
    step(3'b110, 1'b0, "R9 k4 fires");

    // R10: disabled source B leaves phase untouched
    cfg(5'd1, 5'd1, 3'b001, 3'b100);
    step(3'b000, 1'b1, "R7 clear");
    for (int j = 0; j < 5; j++) step(3'b010, 1'b0, "R10 disabled B");
    step(3'b001, 1'b0, "R10 A k0");
    step(3'b001, 1'b0, "R10 A k1 fires");

    // R7: mid-window clear restarts the window
    cfg(5'd3, 5'd2, 3'b001, 3'b001);
    step(3'b000, 1'b1, "R7 clear");
    step(3'b001, 1'b0, "R7 k0");
    step(3'b001, 1'b0, "R7 k1");
    step(3'b001, 1'b1, "R7 off with event");
    step(3'b001, 1'b0, "R7 k0 again");
    step(3'b001, 1'b0, "R7 k1 again");
    step(3'b001, 1'b0, "R7 k2 fires");

    // R6: offset above ratio wraps
    cfg(5'd2, 5'd7, 3'b100, 3'b000);
    step(3'b000, 1'b1, "R7 clear");
    for (int j = 0; j < 6; j++) step(3'b100, 1'b0, "R6 wrap");

    // R8: single-cycle pulse, idle afterwards
    step(3'b000, 1'b0, "R8 idle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule